// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Engine

This block is the host-side sequencer for enhanced parallel port transfers. A host register access arrives as an active-low write or read strobe together with a 3-bit port select. Select value 0 is the address port and values 1 to 4 are the four data ports. A falling host strobe starts one transfer on the peripheral side. For a write, the byte is driven onto the peripheral data lines with its bits unchanged. For a read, the byte found on the lines is returned to the host.

Address-port transfers use the address strobe and data-port transfers use the data strobe. Both kinds share the one 8-bit data bus. The handshake is interlocked with the peripheral wait line: the strobe is held until wait rises, then released, and the transfer ends when wait falls. A clock-count guard ends a transfer that the peripheral never answers and raises a timeout flag. All host and peripheral inputs are taken as synchronous to `clk`.

The controller is a four-state machine:
- `ST_IDLE` waits for a start.
- `ST_WR_SETUP` is write only. It lasts while the host write strobe is still low, and the bus shows the live host byte.
- `ST_STROBE` holds the peripheral strobe low.
- `ST_RELEASE` has the strobe released and waits for wait to fall.

The transitions are:
- Start-write: `ST_IDLE` to `ST_WR_SETUP`.
- Start-read: `ST_IDLE` to `ST_STROBE`.
- Host-release: `ST_WR_SETUP` to `ST_STROBE`, on the rising host write strobe, latching the byte.
- Wait-high: `ST_STROBE` to `ST_RELEASE`.
- Wait-low: `ST_RELEASE` to `ST_IDLE`.
- Expire: `ST_STROBE` or `ST_RELEASE` to `ST_IDLE`.

Top module: `epp_cycle_engine`

## Requirements
- R1: A host strobe starts a transfer only when `epp_mode` is 1, `host_sel` is 0 to 4, and the engine is idle. Any other strobe leaves `busy`, both peripheral strobes, `per_wr_n` and `pd_oe` unchanged.
- R2: During a write transfer, `per_wr_n` is 0 and `pd_oe` is 1 from the clock after the falling host write strobe until the transfer ends. Host data bit n appears on `pd_out` bit n.
- R3: The byte on `host_wdata` is latched on the rising host write strobe. `pd_out` holds that byte for the rest of the transfer, even if `host_wdata` changes.
- R4: Select 0 pulses `addr_stb_n` low and selects 1 to 4 pulse `data_stb_n` low. The two are never low together.
- R5: A peripheral strobe stays low until `per_wait` is 1, then goes high on the next clock. The transfer ends (`busy` 0) on the clock after `per_wait` returns to 0.
- R6: During a read transfer, `per_wr_n` is 1 and `pd_oe` is 0. `pd_in` is captured into `host_rdata` on the clock where `per_wait` is first seen high, and `host_rdata` holds it afterwards.
- R7: If a transfer is still in `ST_STROBE` or `ST_RELEASE` after `TIMEOUT_CLKS` clocks, it ends and `timeout_flag` becomes 1. The next transfer start clears the flag.
- R8: After reset, `busy` is 0, both strobes and `per_wr_n` are 1, `pd_oe` is 0, and `host_rdata` and `timeout_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| epp_mode | input | 1 | 1 enables the enhanced parallel port registers |
| host_sel | input | 3 | 0 = address port, 1..4 = data ports |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Last byte read from the peripheral |
| pd_out | output | 8 | Peripheral data out |
| pd_in | input | 8 | Peripheral data in |
| pd_oe | output | 1 | Peripheral data output enable |
| addr_stb_n | output | 1 | Address strobe, active low |
| data_stb_n | output | 1 | Data strobe, active low |
| per_wr_n | output | 1 | Peripheral direction: 0 write, 1 read |
| per_wait | input | 1 | Peripheral wait handshake |
| busy | output | 1 | A transfer is in progress |
| timeout_flag | output | 1 | The last transfer expired |

## Verification
The hardest situation to reach is a write whose host data changes after the host write strobe has risen while the peripheral strobe is still low. The latch-on-trailing-edge rule can only be seen there. The stimulus drives a wrong byte when the write strobe falls and puts the real byte on the bus just before the strobe rises. It then inverts the bus while the peripheral handshake is still running, and checks that `pd_out` keeps the byte seen at the rising edge. The timeout path is reached by a read whose wait line never rises, counted against a shortened limit.

// File: rtl/epp_pkg.sv
package epp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WR_SETUP = 2'd1,
        ST_STROBE   = 2'd2,
        ST_RELEASE  = 2'd3
    } epp_state_e;

    localparam int unsigned NUM_DATA_PORTS = 4;
    localparam logic [2:0]  SEL_ADDR       = 3'd0;

endpackage

// File: rtl/epp_edge_detect.sv
module epp_edge_detect #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobe_n,
    output logic [N-1:0] fall,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_q;

    for (genvar g = 0; g < N; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q[g] <= 1'b1;
            else        prev_q[g] <= strobe_n[g];
        end
        assign fall[g] = prev_q[g] & ~strobe_n[g];
        assign rise[g] = ~prev_q[g] & strobe_n[g];
    end
endmodule

// File: rtl/epp_timeout_timer.sv
module epp_timeout_timer #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (!run)    cnt_q <= '0;
        else if (!expired) cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/epp_cycle_fsm.sv
module epp_cycle_fsm
    import epp_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_wr,
    input  logic          start_rd,
    input  logic          start_addr,
    input  logic          host_wr_rise,
    input  logic [DW-1:0] host_wdata,
    input  logic [DW-1:0] pd_in,
    input  logic          per_wait,
    input  logic          expired,
    output logic          timer_run,
    output logic [DW-1:0] host_rdata,
    output logic [DW-1:0] pd_out,
    output logic          pd_oe,
    output logic          addr_stb_n,
    output logic          data_stb_n,
    output logic          per_wr_n,
    output logic          busy,
    output logic          timeout_flag
);
    epp_state_e    state_q, state_d;
    logic          is_write_q;
    logic          is_addr_q;
    logic [DW-1:0] data_q;
    logic [DW-1:0] rdata_q;
    logic          tmo_q;
    logic          starting;

    assign starting = (state_q == ST_IDLE) && (start_wr || start_rd);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_wr)      state_d = ST_WR_SETUP;
                else if (start_rd) state_d = ST_STROBE;
            end
            ST_WR_SETUP: begin
                if (host_wr_rise)  state_d = ST_STROBE;
            end
            ST_STROBE: begin
                if (per_wait)      state_d = ST_RELEASE;
                else if (expired)  state_d = ST_IDLE;
            end
            ST_RELEASE: begin
                if (!per_wait || expired) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            is_write_q <= 1'b0;
            is_addr_q  <= 1'b0;
            data_q     <= '0;
            rdata_q    <= '0;
            tmo_q      <= 1'b0;
        end else begin
            state_q <= state_d;
            if (starting) begin
                is_write_q <= start_wr;
                is_addr_q  <= start_addr;
                tmo_q      <= 1'b0;
            end
            if (state_q == ST_WR_SETUP && host_wr_rise)
                data_q <= host_wdata;
            if (state_q == ST_STROBE && per_wait && !is_write_q)
                rdata_q <= pd_in;
            if (expired && state_d == ST_IDLE &&
                (state_q == ST_STROBE || state_q == ST_RELEASE))
                tmo_q <= 1'b1;
        end
    end

    always_comb begin
        timer_run  = 1'b0;
        addr_stb_n = 1'b1;
        data_stb_n = 1'b1;
        per_wr_n   = 1'b1;
        pd_oe      = 1'b0;
        pd_out     = data_q;
        busy       = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
            end
            ST_WR_SETUP: begin
                per_wr_n = 1'b0;
                pd_oe    = 1'b1;
                pd_out   = host_wdata;
            end
            ST_STROBE: begin
                timer_run  = 1'b1;
                addr_stb_n = !is_addr_q;
                data_stb_n = is_addr_q;
                per_wr_n   = !is_write_q;
                pd_oe      = is_write_q;
            end
            ST_RELEASE: begin
                timer_run = 1'b1;
                per_wr_n  = !is_write_q;
                pd_oe     = is_write_q;
            end
            default: busy = 1'b0;
        endcase
    end

    assign host_rdata   = rdata_q;
    assign timeout_flag = tmo_q;
endmodule

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine
    import epp_pkg::*;
#(
    parameter int unsigned TIMEOUT_CLKS = 16,
    parameter int unsigned DW           = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          epp_mode,
    input  logic [2:0]    host_sel,
    input  logic          host_wr_n,
    input  logic          host_rd_n,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic [DW-1:0] pd_out,
    input  logic [DW-1:0] pd_in,
    output logic          pd_oe,
    output logic          addr_stb_n,
    output logic          data_stb_n,
    output logic          per_wr_n,
    input  logic          per_wait,
    output logic          busy,
    output logic          timeout_flag
);
    localparam logic [2:0] SEL_LAST = 3'(NUM_DATA_PORTS);

    logic [1:0] fall, rise;
    logic       sel_ok, start_wr, start_rd, start_addr;
    logic       timer_run, expired;

    epp_edge_detect #(.N(2)) i_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n ({host_rd_n, host_wr_n}),
        .fall     (fall),
        .rise     (rise)
    );

    assign sel_ok     = epp_mode && (host_sel <= SEL_LAST);
    assign start_wr   = sel_ok && fall[0];
    assign start_rd   = sel_ok && fall[1] && !fall[0];
    assign start_addr = (host_sel == SEL_ADDR);

    epp_timeout_timer #(.LIMIT(TIMEOUT_CLKS)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (timer_run),
        .expired (expired)
    );

    epp_cycle_fsm #(.DW(DW)) i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_wr     (start_wr),
        .start_rd     (start_rd),
        .start_addr   (start_addr),
        .host_wr_rise (rise[0]),
        .host_wdata   (host_wdata),
        .pd_in        (pd_in),
        .per_wait     (per_wait),
        .expired      (expired),
        .timer_run    (timer_run),
        .host_rdata   (host_rdata),
        .pd_out       (pd_out),
        .pd_oe        (pd_oe),
        .addr_stb_n   (addr_stb_n),
        .data_stb_n   (data_stb_n),
        .per_wr_n     (per_wr_n),
        .busy         (busy),
        .timeout_flag (timeout_flag)
    );
endmodule

// File: rtl/epp_cycle_checker.sv
module epp_cycle_checker #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          epp_mode,
    input logic          per_wait,
    input logic          addr_stb_n,
    input logic          data_stb_n,
    input logic          per_wr_n,
    input logic          pd_oe,
    input logic [DW-1:0] pd_out,
    input logic          busy,
    input logic          timeout_flag
);
    logic stb_low;
    assign stb_low = !addr_stb_n || !data_stb_n;

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(!addr_stb_n && !data_stb_n)); // R4

    AST_MODE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (!epp_mode && !busy) |=> !busy); // R1

    AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        pd_oe |-> !per_wr_n); // R6

    AST_STB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_low && !per_wait) |=> (stb_low || timeout_flag)); // R5

    AST_STB_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_low && per_wait) |=> !stb_low); // R5

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_low && pd_oe) |=> ($stable(pd_out) || !pd_oe)); // R3

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (addr_stb_n && data_stb_n && per_wr_n && !pd_oe)); // R8
endmodule

bind epp_cycle_engine epp_cycle_checker #(.DW(DW)) i_epp_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .epp_mode     (epp_mode),
    .per_wait     (per_wait),
    .addr_stb_n   (addr_stb_n),
    .data_stb_n   (data_stb_n),
    .per_wr_n     (per_wr_n),
    .pd_oe        (pd_oe),
    .pd_out       (pd_out),
    .busy         (busy),
    .timeout_flag (timeout_flag)
);

// File: tb/test_epp_cycle_engine.sv
`timescale 1ns/1ps
module test_epp_cycle_engine;
    localparam int LIM = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       epp_mode = 1'b1;
    logic [2:0] host_sel = 3'd0;
    logic       host_wr_n = 1'b1, host_rd_n = 1'b1;
    logic [7:0] host_wdata = 8'h00, pd_in = 8'h00;
    logic       per_wait = 1'b0;
    logic [7:0] host_rdata, pd_out;
    logic       pd_oe, addr_stb_n, data_stb_n, per_wr_n, busy, timeout_flag;

    int checks = 0, failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    epp_cycle_engine #(.TIMEOUT_CLKS(LIM)) i_epp_cycle_engine (
        .clk(clk), .rst_n(rst_n), .epp_mode(epp_mode), .host_sel(host_sel),
        .host_wr_n(host_wr_n), .host_rd_n(host_rd_n), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .pd_out(pd_out), .pd_in(pd_in), .pd_oe(pd_oe),
        .addr_stb_n(addr_stb_n), .data_stb_n(data_stb_n), .per_wr_n(per_wr_n),
        .per_wait(per_wait), .busy(busy), .timeout_flag(timeout_flag)
    );

    // {is_read, sel[2:0], byte[7:0]}
    localparam logic [11:0] VEC [0:5] = '{
        {1'b0, 3'd0, 8'hA5}, {1'b0, 3'd1, 8'h3C}, {1'b0, 3'd4, 8'h81},
        {1'b1, 3'd0, 8'h5A}, {1'b1, 3'd2, 8'hC3}, {1'b1, 3'd3, 8'h7E}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] sel, input logic [7:0] d);
        host_sel = sel; host_wdata = ~d; host_wr_n = 1'b0;
        @(negedge clk);
        check("R2 wr_n low in setup", per_wr_n, 0);
        check("R2 oe on in setup", pd_oe, 1);
        host_wdata = d; host_wr_n = 1'b1;
        @(negedge clk);
        host_wdata = ~d;
        check("R4 addr strobe", addr_stb_n, (sel == 0) ? 0 : 1);
        check("R4 data strobe", data_stb_n, (sel == 0) ? 1 : 0);
        check("R3 latched byte", pd_out, d);
        check("R2 wr_n low", per_wr_n, 0);
        per_wait = 1'b1;
        @(negedge clk);
        check("R5 strobes released", {addr_stb_n, data_stb_n}, 2'b11);
        check("R3 byte held", pd_out, d);
        check("R5 busy in release", busy, 1);
        per_wait = 1'b0;
        @(negedge clk);
        check("R5 cycle ended", busy, 0);
        check("R2 oe off after", pd_oe, 0);
    endtask

    task automatic host_read(input logic [2:0] sel, input logic [7:0] d);
        host_sel = sel; pd_in = d; host_rd_n = 1'b0;
        @(negedge clk);
        check("R4 addr strobe rd", addr_stb_n, (sel == 0) ? 0 : 1);
        check("R4 data strobe rd", data_stb_n, (sel == 0) ? 1 : 0);
        check("R6 wr_n high", per_wr_n, 1);
        check("R6 oe off", pd_oe, 0);
        host_rd_n = 1'b1; per_wait = 1'b1;
        @(negedge clk);
        pd_in = ~d;
        check("R6 captured", host_rdata, d);
        per_wait = 1'b0;
        @(negedge clk);
        check("R5 read ended", busy, 0);
        check("R6 rdata held", host_rdata, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 reset state
        check("R8 busy", busy, 0);
        check("R8 strobes", {addr_stb_n, data_stb_n, per_wr_n}, 3'b111);
        check("R8 oe", pd_oe, 0);
        check("R8 rdata", host_rdata, 0);
        check("R8 timeout", timeout_flag, 0);

        for (int i = 0; i < 6; i++) begin
            if (VEC[i][11]) host_read(VEC[i][10:8], VEC[i][7:0]);
            else            host_write(VEC[i][10:8], VEC[i][7:0]);
            @(negedge clk);
        end

        // R1: mode off ignores write
        epp_mode = 1'b0; host_sel = 3'd1; host_wr_n = 1'b0;
        @(negedge clk);
        check("R1 mode off busy", busy, 0);
        check("R1 mode off oe", pd_oe, 0);
        host_wr_n = 1'b1;
        @(negedge clk);
        check("R1 mode off strobes", {addr_stb_n, data_stb_n, per_wr_n}, 3'b111);
        epp_mode = 1'b1;
        // R1: select 5 ignored
        host_sel = 3'd5; host_rd_n = 1'b0;
        @(negedge clk);
        check("R1 bad sel busy", busy, 0);
        check("R1 bad sel strobe", data_stb_n, 1);
        host_rd_n = 1'b1;
        @(negedge clk);

        // R7: read with no wait response
        host_sel = 3'd1; host_rd_n = 1'b0; pd_in = 8'h99;
        @(negedge clk);
        host_rd_n = 1'b1;
        repeat (LIM - 1) @(negedge clk);
        check("R7 still busy before limit", busy, 1);
        check("R7 strobe held before limit", data_stb_n, 0);
        @(negedge clk);
        check("R7 ended at limit", busy, 0);
        check("R7 flag set", timeout_flag, 1);
        check("R7 rdata untouched", host_rdata, 8'h7E);
        @(negedge clk);
        host_write(3'd2, 8'h0F);
        check("R7 flag cleared by next start", timeout_flag, 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule